// File: doc/BRIEF.md
# Trigger Pattern Slot Loader

This block is the sequencer that fills every pattern slot of a programmable trigger device through a word-wide serial shifter. A single start pulse launches a complete load. The chip select goes high and a long settling delay runs. The block then walks all slots in ascending order and presents two words for each one. A slot below the configured pattern count gets its table entries. A slot at or above that count gets a fixed code that never triggers, sent twice. After the last slot, two more timed intervals bracket the release of the select line, and then a done flag is raised.

Each word goes to the shifter over a valid/ready handshake. After each slot a one-cycle heartbeat pulse is given, so that a supervisor can see the load is still advancing. All three delays are parameters counted in clock cycles. With the default parameters they amount to several seconds of real time. The pattern table is read from flat input vectors driven by a register file.

Top module: `tla_loader`

## Requirements
- R1: During and after a synchronous reset the block is idle: `cs_out`, `word_valid`, `slot_beat`, `busy` and `done` are all low.
- R2: A `start` pulse in idle raises `cs_out` and `busy` on the next clock edge. The first `word_valid` rises exactly PRE_CYCLES clock cycles after `cs_out` rises.
- R3: Slots 0 to NUM_SLOTS-1 are sent in ascending order. For a slot whose index is below `pat_count`, the high word `pat_hi_flat[i*WORD_W +: WORD_W]` is sent first, then the low word `pat_lo_flat[i*WORD_W +: WORD_W]`. A `pat_count` above NUM_SLOTS makes every slot configured.
- R4: For a slot whose index is at or above `pat_count`, the NO_TRIG constant (bench value 16'hFFFF) is sent as both its high and its low word.
- R5: A word is transferred on a clock edge where `word_valid` and `word_ready` are both high. While `word_valid` is high and `word_ready` is low, `word_valid` stays high and `word_data` holds its value. Every load transfers exactly 2*NUM_SLOTS words. `word_valid` is high only while `cs_out` is high.
- R6: `slot_beat` is high for exactly one cycle: the cycle after each slot's low word is transferred. This gives NUM_SLOTS pulses per load.
- R7: `cs_out` falls POST_CYCLES clock cycles after the edge that transfers the final low word. `done` rises HOLD_CYCLES cycles after `cs_out` falls, and `busy` drops at the same edge.
- R8: `done` stays high until the next accepted `start`, which clears it on the same edge that raises `cs_out`. A `start` while `busy` is high is ignored: no second select rise and no extra words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a full load (acted on only when idle) |
| pat_count | input | CNT_W | Number of configured pattern slots |
| pat_hi_flat | input | NUM_SLOTS*WORD_W | High words, slot i at bits [i*WORD_W +: WORD_W] |
| pat_lo_flat | input | NUM_SLOTS*WORD_W | Low words, slot i at bits [i*WORD_W +: WORD_W] |
| word_ready | input | 1 | Shifter can accept a word |
| word_valid | output | 1 | `word_data` holds a word for the shifter |
| word_data | output | WORD_W | Word presented to the shifter |
| cs_out | output | 1 | Chip select to the trigger device |
| slot_beat | output | 1 | One-cycle pulse after each slot completes |
| busy | output | 1 | A load is in progress |
| done | output | 1 | Last load has completed |

## Verification
Two kinds of coincidence get attention. The first is a slot boundary with `word_ready` held high. There, the heartbeat for one slot lands in the same cycle as the first transfer of the next slot's high word. The bench forces this with continuous ready, and judges it by the word order and by the exact cycle of every heartbeat. The second is a `start` arriving while a load is already running, in both the settling phase and the streaming phase. Such a pulse must not disturb the sequence. It is judged by a single select rise and an unchanged word count. A further restart issued while `done` is high must clear `done` in the same edge that raises the select.

// File: rtl/tla_pkg.sv
package tla_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_PRE,
    S_HI,
    S_LO,
    S_POST,
    S_HOLD
  } tla_state_e;
endpackage

// File: rtl/tla_delay_timer.sv
module tla_delay_timer #(
  parameter int unsigned MAX_CYCLES = 16,
  localparam int unsigned CW = (MAX_CYCLES < 2) ? 1 : $clog2(MAX_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);

  // R7
  count_down_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/tla_word_select.sv
module tla_word_select #(
  parameter int unsigned NUM_SLOTS = 4,
  parameter int unsigned WORD_W    = 16,
  parameter logic [WORD_W-1:0] NO_TRIG = '1,
  localparam int unsigned IDX_W = (NUM_SLOTS < 2) ? 1 : $clog2(NUM_SLOTS),
  localparam int unsigned CNT_W = $clog2(NUM_SLOTS + 1)
) (
  input  logic [IDX_W-1:0]            sel_idx,
  input  logic [CNT_W-1:0]            pat_count,
  input  logic [NUM_SLOTS*WORD_W-1:0] pat_hi_flat,
  input  logic [NUM_SLOTS*WORD_W-1:0] pat_lo_flat,
  output logic [WORD_W-1:0]           hi_word,
  output logic [WORD_W-1:0]           lo_word
);
  logic [WORD_W-1:0] hi_arr [NUM_SLOTS];
  logic [WORD_W-1:0] lo_arr [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] hit;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    assign hi_arr[g] = pat_hi_flat[g*WORD_W +: WORD_W];
    assign lo_arr[g] = pat_lo_flat[g*WORD_W +: WORD_W];
    assign hit[g]    = (sel_idx == IDX_W'(g));
  end

  logic configured;
  assign configured = (CNT_W'(sel_idx) < pat_count);

  always_comb begin
    hi_word = NO_TRIG;
    lo_word = NO_TRIG;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (hit[i] && configured) begin
        hi_word = hi_arr[i];
        lo_word = lo_arr[i];
      end
    end
  end
endmodule

// File: rtl/tla_loader.sv
module tla_loader
  import tla_pkg::*;
#(
  parameter int unsigned NUM_SLOTS   = 4,
  parameter int unsigned WORD_W      = 16,
  parameter logic [WORD_W-1:0] NO_TRIG = '1,
  parameter int unsigned PRE_CYCLES  = 200_000_000,
  parameter int unsigned POST_CYCLES = 150_000_000,
  parameter int unsigned HOLD_CYCLES = 150_000_000,
  localparam int unsigned IDX_W = (NUM_SLOTS < 2) ? 1 : $clog2(NUM_SLOTS),
  localparam int unsigned CNT_W = $clog2(NUM_SLOTS + 1)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start,
  input  logic [CNT_W-1:0]            pat_count,
  input  logic [NUM_SLOTS*WORD_W-1:0] pat_hi_flat,
  input  logic [NUM_SLOTS*WORD_W-1:0] pat_lo_flat,
  input  logic                        word_ready,
  output logic                        word_valid,
  output logic [WORD_W-1:0]           word_data,
  output logic                        cs_out,
  output logic                        slot_beat,
  output logic                        busy,
  output logic                        done
);
  localparam int unsigned TMR_MAX0 = (PRE_CYCLES > POST_CYCLES) ? PRE_CYCLES : POST_CYCLES;
  localparam int unsigned TMR_MAX  = (TMR_MAX0 > HOLD_CYCLES) ? TMR_MAX0 : HOLD_CYCLES;
  localparam int unsigned TMR_W    = (TMR_MAX < 2) ? 1 : $clog2(TMR_MAX + 1);
  localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(NUM_SLOTS - 1);

  tla_state_e state;
  logic [IDX_W-1:0] slot;
  logic [IDX_W-1:0] sel_idx;
  logic [WORD_W-1:0] hi_word, lo_word;
  logic tmr_load, tmr_exp;
  logic [TMR_W-1:0] tmr_val;
  logic xfer;

  assign xfer = word_valid && word_ready;

  // In the low-word state the selector looks ahead to the next slot.
  assign sel_idx = (state == S_LO) ? IDX_W'(slot + 1'b1) : slot;

  tla_word_select #(
    .NUM_SLOTS(NUM_SLOTS),
    .WORD_W   (WORD_W),
    .NO_TRIG  (NO_TRIG)
  ) u_sel (
    .sel_idx    (sel_idx),
    .pat_count  (pat_count),
    .pat_hi_flat(pat_hi_flat),
    .pat_lo_flat(pat_lo_flat),
    .hi_word    (hi_word),
    .lo_word    (lo_word)
  );

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state)
      S_IDLE: if (start) begin
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(PRE_CYCLES - 1);
      end
      S_LO: if (xfer && slot == LAST_SLOT) begin
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(POST_CYCLES - 1);
      end
      S_POST: if (tmr_exp) begin
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(HOLD_CYCLES - 1);
      end
      default: ;
    endcase
  end

  tla_delay_timer #(.MAX_CYCLES(TMR_MAX)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .load_val(tmr_val),
    .expired (tmr_exp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      slot       <= '0;
      cs_out     <= 1'b0;
      word_valid <= 1'b0;
      word_data  <= '0;
      slot_beat  <= 1'b0;
      done       <= 1'b0;
    end else begin
      slot_beat <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            cs_out <= 1'b1;
            done   <= 1'b0;
            slot   <= '0;
            state  <= S_PRE;
          end
        end
        S_PRE: begin
          if (tmr_exp) begin
            word_valid <= 1'b1;
            word_data  <= hi_word;
            state      <= S_HI;
          end
        end
        S_HI: begin
          if (xfer) begin
            word_data <= lo_word;
            state     <= S_LO;
          end
        end
        S_LO: begin
          if (xfer) begin
            slot_beat <= 1'b1;
            if (slot == LAST_SLOT) begin
              word_valid <= 1'b0;
              state      <= S_POST;
            end else begin
              slot      <= IDX_W'(slot + 1'b1);
              word_data <= hi_word;
              state     <= S_HI;
            end
          end
        end
        S_POST: begin
          if (tmr_exp) begin
            cs_out <= 1'b0;
            state  <= S_HOLD;
          end
        end
        S_HOLD: begin
          if (tmr_exp) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy = (state != S_IDLE);

  // R5
  valid_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (word_valid && !word_ready) |=> (word_valid && $stable(word_data)));

  // R5
  valid_in_cs_chk: assert property (@(posedge clk) disable iff (rst)
    word_valid |-> cs_out);

  // R6
  beat_after_lo_chk: assert property (@(posedge clk) disable iff (rst)
    slot_beat |-> $past(state == S_LO && xfer));

  // R8
  done_busy_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(done && busy));

  // R2
  cs_rise_from_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_out) |-> ($past(state) == S_IDLE && $past(start)));
endmodule

// File: tb/tla_loader_bench.sv
module tla_loader_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;
  localparam int WW = 16;
  localparam int PRE = 20;
  localparam int POST = 12;
  localparam int HOLD = 8;
  localparam logic [WW-1:0] NT = 16'hFFFF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [2:0] pat_count = '0;
  logic [NS*WW-1:0] pat_hi_flat, pat_lo_flat;
  logic word_ready = 1'b0;
  logic word_valid, cs_out, slot_beat, busy, done;
  logic [WW-1:0] word_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  tla_loader #(
    .NUM_SLOTS(NS), .WORD_W(WW), .NO_TRIG(NT),
    .PRE_CYCLES(PRE), .POST_CYCLES(POST), .HOLD_CYCLES(HOLD)
  ) u_tla_loader (
    .clk(clk), .rst(rst), .start(start), .pat_count(pat_count),
    .pat_hi_flat(pat_hi_flat), .pat_lo_flat(pat_lo_flat),
    .word_ready(word_ready), .word_valid(word_valid), .word_data(word_data),
    .cs_out(cs_out), .slot_beat(slot_beat), .busy(busy), .done(done)
  );

  int checks = 0;
  int errors = 0;
  int ready_mode = 0;

  // monitor state, sampled on the falling edge
  int cyc = 0;
  logic cs_q = 1'b0, valid_q = 1'b0, done_q = 1'b0;
  int t_cs_rise, t_valid_rise, t_last_acc, t_cs_fall, t_done_rise;
  logic [WW-1:0] wlog [32];
  int nlog = 0, nbeat = 0, ncsrise = 0, beat_err = 0, csv_err = 0;
  int exp_beat_at = -1;

  initial begin
    for (int i = 0; i < NS; i++) begin
      pat_hi_flat[i*WW +: WW] = 16'hA000 + WW'(i);
      pat_lo_flat[i*WW +: WW] = 16'h5000 + WW'(i);
    end
  end

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (!rst) begin
      if (cs_out && !cs_q) begin t_cs_rise = cyc; ncsrise++; end
      if (!cs_out && cs_q) t_cs_fall = cyc;
      if (word_valid && !valid_q) t_valid_rise = cyc;
      if (done && !done_q) t_done_rise = cyc;
      if (word_valid && !cs_out) csv_err++;
      if (slot_beat) nbeat++;
      if (slot_beat != (cyc == exp_beat_at)) beat_err++;
      if (word_valid && word_ready) begin
        if (nlog < 32) wlog[nlog] = word_data;
        if (nlog % 2 == 1) exp_beat_at = cyc + 1;
        t_last_acc = cyc;
        nlog++;
      end
    end
    cs_q = cs_out;
    valid_q = word_valid;
    done_q = done;
  end

  initial begin
    forever begin
      @(posedge clk);
      #1;
      case (ready_mode)
        0: word_ready = 1'b1;
        1: word_ready = (cyc % 2 == 0);
        default: word_ready = (cyc % 3 == 0);
      endcase
    end
  end

  task automatic check_int(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_log();
    nlog = 0; nbeat = 0; ncsrise = 0; beat_err = 0; csv_err = 0;
    exp_beat_at = -1;
  endtask

  task automatic pulse_start();
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    @(negedge clk);
    while (!done && n < 3000) begin @(negedge clk); n++; end
    #1;
  endtask

  task automatic check_load(string tag, int cnt);
    int ecnt = (cnt > NS) ? NS : cnt;
    check_int({tag, " R5 word count"}, nlog, 2*NS);
    for (int i = 0; i < 2*NS && i < nlog; i++) begin
      int s = i / 2;
      int ex;
      if (s < ecnt) ex = (i % 2 == 0) ? int'(16'hA000) + s : int'(16'h5000) + s;
      else ex = int'(NT);
      check_int((s < ecnt) ? {tag, " R3 word"} : {tag, " R4 pad word"}, int'(wlog[i]), ex);
    end
    check_int({tag, " R6 beat count"}, nbeat, NS);
    check_int({tag, " R6 beat timing"}, beat_err, 0);
    check_int({tag, " R5 valid outside cs"}, csv_err, 0);
    check_int({tag, " R2 pre delay"}, t_valid_rise - t_cs_rise, PRE);
    check_int({tag, " R7 post delay"}, t_cs_fall - t_last_acc, POST + 1);
    check_int({tag, " R7 hold delay"}, t_done_rise - t_cs_fall, HOLD);
    check_int({tag, " R7 busy low at done"}, int'(busy), 0);
    check_int({tag, " R8 single cs rise"}, ncsrise, 1);
  endtask

  task automatic run_load(string tag, int cnt, int mode);
    ready_mode = mode;
    pat_count = 3'(cnt);
    clear_log();
    pulse_start();
    wait_done();
    check_int({tag, " R7 done"}, int'(done), 1);
    check_load(tag, cnt);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check_int("R1 cs", int'(cs_out), 0);
    check_int("R1 valid", int'(word_valid), 0);
    check_int("R1 beat", int'(slot_beat), 0);
    check_int("R1 busy", int'(busy), 0);
    check_int("R1 done", int'(done), 0);
  endtask

  task automatic t_start_edge();
    ready_mode = 0;
    pat_count = 3'd2;
    clear_log();
    @(posedge clk); #1 start = 1'b1;
    @(negedge clk);
    check_int("R2 cs before edge", int'(cs_out), 0);
    @(posedge clk); #1 start = 1'b0;
    @(negedge clk);
    check_int("R2 cs after edge", int'(cs_out), 1);
    check_int("R2 busy after edge", int'(busy), 1);
    wait_done();
    check_load("start-edge", 2);
  endtask

  task automatic t_busy_ignore();
    ready_mode = 1;
    pat_count = 3'd3;
    clear_log();
    pulse_start();
    repeat (PRE/2) @(posedge clk);
    pulse_start();
    while (nlog < 3) @(negedge clk);
    pulse_start();
    wait_done();
    check_load("busy-ignore R8", 3);
    repeat (10) @(negedge clk);
    check_int("R8 done held", int'(done), 1);
    clear_log();
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    @(negedge clk);
    check_int("R8 done cleared on restart", int'(done), 0);
    check_int("R8 cs on restart", int'(cs_out), 1);
    wait_done();
    check_load("restart", 3);
  endtask

  task automatic t_mid_reset();
    ready_mode = 2;
    pat_count = 3'd4;
    clear_log();
    pulse_start();
    while (nlog < 3) @(negedge clk);
    @(posedge clk); #1 rst = 1'b1;
    @(posedge clk); #1;
    @(negedge clk);
    check_int("R1 mid cs", int'(cs_out), 0);
    check_int("R1 mid valid", int'(word_valid), 0);
    check_int("R1 mid busy", int'(busy), 0);
    check_int("R1 mid done", int'(done), 0);
    @(posedge clk); #1 rst = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_start_edge();
    run_load("count2 ready-high", 2, 0);
    run_load("count0 alternate", 0, 1);
    run_load("count4 sparse", 4, 2);
    run_load("count7 over", 7, 0);
    t_busy_ignore();
    t_mid_reset();
    run_load("after reset", 1, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule